// File: doc/BRIEF.md
# Timer and Serial Interrupt Flag Register

This block holds the interrupt request flags of a capture/reload timer and of a serial port. Hardware event strobes set the flags. Software reads both control registers, and it clears or writes flags through a register write port. Two request lines go to the interrupt controller. The timer request combines the overflow flag with the external-event flag. The serial request combines the transmit-done flag with the receive-done flag.

The external-event flag comes from the raw capture/reload pin. The pin passes through a synchroniser, and a falling edge is detected on the synchronised signal. An enable bit in the timer control register gates the flag. The up/down counting mode input masks this flag out of the timer request. An overflow does not set the overflow flag while either baud-clock select bit is 1.

The vector acknowledge inputs are present but do not clear any flag. Only a register write clears a flag.

Top module: `tmr_ser_irq_flags`

## Requirements
- R1: After reset, both control registers read 00h and both request lines are 0.
- R2: An overflow strobe sets timer control bit 7 on the next clock edge when bits 5 and 4 are both 0, and `tmr_irq` then reads 1.
- R3: An overflow strobe leaves bit 7 unchanged when bit 5 or bit 4 of the timer control register is 1.
- R4: A 1-to-0 transition on `cap_pin` sets timer control bit 6 when enable bit 3 is 1. The flag is visible after the third rising edge following the pin change, and not after the second. A rising transition never sets bit 6, and a falling transition with bit 3 at 0 does not set it.
- R5: While `updown_mode` is 1, bit 6 does not drive `tmr_irq`, and bit 6 keeps its value.
- R6: A transmit-done strobe sets serial control bit 1, and a receive-done strobe sets bit 0, each on the next clock edge. `ser_irq` is then 1.
- R7: `tmr_ack` and `ser_ack` have no effect on any register bit or request line.
- R8: A write strobe loads all 8 bits of the addressed register from `wdata` on the next edge. This applies to both registers. Writing 0 clears a flag, and writing 1 sets it.
- R9: When a hardware set and a software write hit the same flag in the same cycle, the flag ends up 1.
- R10: `tmr_irq` equals bit 7 OR (bit 6 AND NOT `updown_mode`). `ser_irq` equals serial bit 1 OR bit 0. Both follow the register without an added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_evt | input | 1 | Timer overflow strobe |
| cap_pin | input | 1 | Raw external capture/reload pin |
| updown_mode | input | 1 | Up/down counting mode select |
| txdone_evt | input | 1 | Serial transmission finished strobe |
| rxdone_evt | input | 1 | Serial byte received strobe |
| tmr_ack | input | 1 | Timer vector acknowledge (no effect on flags) |
| ser_ack | input | 1 | Serial vector acknowledge (no effect on flags) |
| wr_tctl | input | 1 | Write strobe for the timer control register |
| wr_sctl | input | 1 | Write strobe for the serial control register |
| wdata | input | 8 | Write data |
| tctl_q | output | 8 | Timer control register value |
| sctl_q | output | 8 | Serial control register value |
| tmr_irq | output | 1 | Timer interrupt request |
| ser_irq | output | 1 | Serial interrupt request |

## Verification
The hardest case to reach is the pin-driven flag. It depends on the synchroniser delay, on the enable bit, and on the edge direction. The stimulus first parks the pin high long enough to fill the synchroniser. It then drops the pin and checks bit 6 after the second edge and again after the third. This is repeated for both enable settings and for rising transitions. Write-versus-event collisions are placed in a single cycle by raising the strobe and the write together. Full sweeps of `wdata` over both registers, under both `updown_mode` values, cover the request equations.

// File: rtl/tmr_ser_irq_flags.sv
module tmr_ser_irq_flags #(
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_evt,
  input  logic       cap_pin,
  input  logic       updown_mode,
  input  logic       txdone_evt,
  input  logic       rxdone_evt,
  input  logic       tmr_ack,
  input  logic       ser_ack,
  input  logic       wr_tctl,
  input  logic       wr_sctl,
  input  logic [7:0] wdata,
  output logic [7:0] tctl_q,
  output logic [7:0] sctl_q,
  output logic       tmr_irq,
  output logic       ser_irq
);
  localparam int B_OVF = 7;
  localparam int B_EXT = 6;
  localparam int B_RXC = 5;
  localparam int B_TXC = 4;
  localparam int B_EEN = 3;
  localparam int B_TXF = 1;
  localparam int B_RXF = 0;

  logic [SYNC_LEN:0] pin_sh;
  logic              pin_fall;
  logic              ovf_set, ext_set;
  logic [7:0]        tctl_d, sctl_d;
  logic              unused_ack;

  assign unused_ack = tmr_ack ^ ser_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_sh <= '0;
    else        pin_sh <= {pin_sh[SYNC_LEN-1:0], cap_pin};
  end

  assign pin_fall = pin_sh[SYNC_LEN] & ~pin_sh[SYNC_LEN-1];
  assign ovf_set  = ovf_evt & ~(tctl_q[B_RXC] | tctl_q[B_TXC]);
  assign ext_set  = pin_fall & tctl_q[B_EEN];

  always_comb begin
    tctl_d = wr_tctl ? wdata : tctl_q;
    sctl_d = wr_sctl ? wdata : sctl_q;
    if (ovf_set)    tctl_d[B_OVF] = 1'b1;
    if (ext_set)    tctl_d[B_EXT] = 1'b1;
    if (txdone_evt) sctl_d[B_TXF] = 1'b1;
    if (rxdone_evt) sctl_d[B_RXF] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tctl_q <= 8'h00;
      sctl_q <= 8'h00;
    end else begin
      tctl_q <= tctl_d;
      sctl_q <= sctl_d;
    end
  end

  assign tmr_irq = tctl_q[B_OVF] | (tctl_q[B_EXT] & ~updown_mode);
  assign ser_irq = sctl_q[B_TXF] | sctl_q[B_RXF];
endmodule

module tmr_ser_irq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovf_evt,
  input logic       updown_mode,
  input logic       txdone_evt,
  input logic       rxdone_evt,
  input logic       wr_tctl,
  input logic       wr_sctl,
  input logic [7:0] tctl_q,
  input logic [7:0] sctl_q,
  input logic       tmr_irq,
  input logic       ser_irq
);
  p_ovf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !tctl_q[5] && !tctl_q[4]) |=> tctl_q[7]);
  p_ovf_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && (tctl_q[5] || tctl_q[4]) && !wr_tctl) |=> (tctl_q[7] == $past(tctl_q[7])));
  p_ud_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (updown_mode && !tctl_q[7]) |-> !tmr_irq);
  p_rx_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rxdone_evt |=> ser_irq);
  p_tflag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tctl_q[7] && !wr_tctl) |=> tctl_q[7]);
  p_sflag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sctl_q[1] && !wr_sctl) |=> sctl_q[1]);
  p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sctl && txdone_evt) |=> sctl_q[1]);
endmodule

bind tmr_ser_irq_flags tmr_ser_irq_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .updown_mode(updown_mode),
  .txdone_evt(txdone_evt), .rxdone_evt(rxdone_evt), .wr_tctl(wr_tctl),
  .wr_sctl(wr_sctl), .tctl_q(tctl_q), .sctl_q(sctl_q),
  .tmr_irq(tmr_irq), .ser_irq(ser_irq)
);

// File: tb/sim_tmr_ser_irq_flags.sv
module sim_tmr_ser_irq_flags;
  logic clk = 0, rst_n = 0;
  logic ovf_evt = 0, cap_pin = 0, updown_mode = 0, txdone_evt = 0, rxdone_evt = 0;
  logic tmr_ack = 0, ser_ack = 0, wr_tctl = 0, wr_sctl = 0;
  logic [7:0] wdata = 0, tctl_q, sctl_q;
  logic tmr_irq, ser_irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_ser_irq_flags u0 (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(bit tsel, logic [7:0] v);
    wdata = v; wr_tctl = tsel; wr_sctl = !tsel;
    tick();
    wr_tctl = 0; wr_sctl = 0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; #1;
    chk("R1 tctl", tctl_q, 8'h00); chk("R1 sctl", sctl_q, 8'h00);
    chk("R1 irq", {tmr_irq, ser_irq}, 8'h00);

    // R2 / R3: overflow under each baud-clock mode pair
    for (int m = 0; m < 4; m++) begin
      wr(1, 8'(m << 4));
      ovf_evt = 1; tick(); ovf_evt = 0;
      chk(m == 0 ? "R2 ovf set" : "R3 ovf blocked", 8'(tctl_q[7]), 8'(m == 0));
      chk("R2/R3 irq", 8'(tmr_irq), 8'(m == 0));
    end

    // R4: pin edges, enable on/off
    for (int en = 0; en < 2; en++) begin
      wr(1, en ? 8'h08 : 8'h00);
      cap_pin = 1; repeat (4) tick();
      chk("R4 rise no set", 8'(tctl_q[6]), 8'h00);
      cap_pin = 0; tick(); tick();
      chk("R4 not yet", 8'(tctl_q[6]), 8'h00);
      tick();
      chk("R4 fall", 8'(tctl_q[6]), 8'(en));
      tick();
      chk("R4 single set", tctl_q, en ? 8'h48 : 8'h00);
    end

    // R5: up/down mode masks bit 6
    updown_mode = 1; #1;
    chk("R5 masked", 8'(tmr_irq), 8'h00);
    tick(); chk("R5 held", 8'(tctl_q[6]), 8'h01);
    updown_mode = 0; #1;
    chk("R5 unmasked", 8'(tmr_irq), 8'h01);

    // R7: acks do nothing
    ovf_evt = 1; tick(); ovf_evt = 0;
    txdone_evt = 1; tick(); txdone_evt = 0;
    tmr_ack = 1; ser_ack = 1; repeat (3) tick(); tmr_ack = 0; ser_ack = 0;
    chk("R7 tctl", tctl_q, 8'hC8); chk("R7 sctl", sctl_q, 8'h02);
    chk("R7 irq", {6'd0, tmr_irq, ser_irq}, 8'h03);

    // R6: each serial strobe
    wr(0, 8'h00); chk("R8 clear irq", 8'(ser_irq), 8'h00);
    rxdone_evt = 1; tick(); rxdone_evt = 0;
    chk("R6 rx", sctl_q, 8'h01); chk("R6 irq", 8'(ser_irq), 8'h01);
    wr(0, 8'h00);
    txdone_evt = 1; tick(); txdone_evt = 0;
    chk("R6 tx", sctl_q, 8'h02); chk("R6 irq tx", 8'(ser_irq), 8'h01);

    // R9: collisions
    wdata = 8'h00; wr_tctl = 1; ovf_evt = 1; tick(); wr_tctl = 0; ovf_evt = 0;
    chk("R9 tctl", tctl_q, 8'h80);
    wdata = 8'h00; wr_sctl = 1; txdone_evt = 1; rxdone_evt = 1; tick();
    wr_sctl = 0; txdone_evt = 0; rxdone_evt = 0;
    chk("R9 sctl", sctl_q, 8'h03);

    // R8 / R10: full write sweep of both registers
    for (int ud = 0; ud < 2; ud++) begin
      updown_mode = ud[0];
      for (int v = 0; v < 256; v++) begin
        wr(1, 8'(v));
        chk("R8 tctl", tctl_q, 8'(v));
        chk("R10 tmr_irq", 8'(tmr_irq), 8'(v[7] | (v[6] & ~ud[0])));
        wr(0, 8'(v));
        chk("R8 sctl", sctl_q, 8'(v));
        chk("R10 ser_irq", 8'(ser_irq), 8'(v[1] | v[0]));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule